// File: doc/BRIEF.md
# External Memory AHB Access Gate

This block sits between an AHB-Lite bus and the request port of an external memory controller. It samples every address phase aimed at it and decides whether the transfer may proceed. A transfer wider than 32 bits is refused. A write that lands in an enabled protected window is refused. A refused transfer gets the two-cycle AHB ERROR response and is never seen downstream. A legal transfer becomes one request on a valid/ready port. The AHB data phase is stretched until the downstream side accepts that request.

Before the request leaves, the block places its byte strobes and data lanes according to an endian-mode bit. It applies the same mapping to read data on the way back. A `busy` output is high while a downstream request is outstanding. The endian-mode bit never changes while `busy` is high. A configuration write made while busy is parked and applied once the port is quiet.

Top module: `extmem_ahb_gate`

## Requirements
- R1: In the first cycle after reset, `hreadyout`=1, `hresp`=0, `req_valid`=0 and `busy`=0, and `endian_mode`=0 (little-endian).
- R2: A transfer is accepted when `hsel`=1, `hready`=1, `htrans[1]`=1 (NONSEQ=2 or SEQ=3) and `hreadyout`=1. A legal accepted transfer raises `req_valid` in the next cycle, carrying `req_addr`=`haddr` and `req_write`=`hwrite`. `req_valid`, `req_addr` and `req_write` hold, and `hreadyout` stays 0, until the cycle where `req_ready`=1.
- R3: An accepted transfer with `hsize` above 2 (above 32 bits) gets an ERROR response and creates no request, whether it is a read or a write.
- R4: Region k (k=0,1) protects address A when `wp_en[k]`=1 and (A & mask_k) == (base_k & mask_k). Base_k is `wp_base[32k+31:32k]` and mask_k is `wp_mask[32k+31:32k]`. A write to a protected address gets an ERROR and no request. A read from a protected address, or any access to a disabled region, completes normally.
- R5: An ERROR response takes two cycles. In the first, `hresp`=1 and `hreadyout`=0. In the second, `hresp`=1 and `hreadyout`=1.
- R6: A cycle with `hsel`=0 or `htrans` IDLE (0) or BUSY (1) leaves `hresp`=0 and `hreadyout`=1, and creates no request.
- R7: With `endian_mode`=0, `req_strb` is set as follows (`hsize` 0=byte, 1=halfword, 2=word): a byte at `haddr[1:0]`=a sets strobe bit a; a halfword sets bits 1:0 when `haddr[1]`=0 and bits 3:2 when `haddr[1]`=1; a word sets all four bits. Data passes unchanged in both directions.
- R8: With `endian_mode`=1, byte and halfword accesses mirror the little-endian strobe (bit i becomes bit 3-i). They also reverse the byte order of `req_wdata` and of the returned read data (byte lane i becomes lane 3-i). Word accesses are not changed.
- R9: In the cycle after the `req_valid`/`req_ready` handshake, `hreadyout`=1 and `hresp`=0. For a read, `hrdata` shows `rsp_rdata` as sampled at the handshake, mapped as in R7 or R8.
- R10: `busy` is 1 in exactly the cycles in which `req_valid` is 1.
- R11: A pulse on `cfg_endian_we` while `busy`=0 loads `cfg_endian_val` into `endian_mode` at that clock edge. While `busy`=1, the value is held and loaded at the first edge at which `busy` is 0. A later write replaces a held value.
- R12: `endian_mode` does not change at any clock edge where `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Address phase address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | Write when 1 |
| hsize | input | 3 | Transfer size code |
| hwdata | input | 32 | Write data, data phase |
| hready | input | 1 | Bus-wide ready |
| hreadyout | output | 1 | This slave's ready |
| hresp | output | 1 | 1 = ERROR |
| hrdata | output | 32 | Read data |
| cfg_endian_we | input | 1 | Endian-mode write strobe |
| cfg_endian_val | input | 1 | Endian value to write (1 = big) |
| endian_mode | output | 1 | Endian mode in force |
| busy | output | 1 | Downstream request outstanding |
| wp_base | input | 64 | Protect window bases, 32 bits per region |
| wp_mask | input | 64 | Protect window masks, 32 bits per region |
| wp_en | input | 2 | Protect window enables |
| req_valid | output | 1 | Downstream request valid |
| req_ready | input | 1 | Downstream request accepted |
| req_addr | output | 32 | Request address |
| req_strb | output | 4 | Request byte strobes |
| req_wdata | output | 32 | Request write data |
| req_write | output | 1 | Request is a write |
| rsp_rdata | input | 32 | Read data, valid with `req_ready` |

## Verification
Every result has a fixed due cycle, counted from the clock edge that samples the address phase. The request or the first ERROR cycle appears one edge later. The second ERROR cycle and the post-handshake completion each appear one edge after that. An endian write lands at the edge that samples it, or at the first quiet edge if it was parked. A behavioural model in the bench steps on the same edges and predicts each output. The outputs are compared half a cycle later, so every output is checked in the cycle it is due, including through the stretched wait states.

// File: rtl/extmem_gate_pkg.sv
// Shared types for the external memory AHB access gate.
// Assumes AHB-Lite encodings for HTRANS and HSIZE.
package extmem_gate_pkg;

    typedef enum logic [2:0] {
        GS_IDLE = 3'd0,
        GS_PEND = 3'd1,
        GS_ERR1 = 3'd2,
        GS_ERR2 = 3'd3,
        GS_DONE = 3'd4
    } gate_state_t;

    localparam logic [2:0] SZ_WORD = 3'd2;

endpackage

// File: rtl/xg_region_match.sv
// Parallel base/mask comparator for write-protect windows.
// Assumes a set mask bit means "compare this address bit".
module xg_region_match #(
    parameter int ADDR_W = 32,
    parameter int NREG   = 2
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [NREG*ADDR_W-1:0] base,
    input  logic [NREG*ADDR_W-1:0] mask,
    input  logic [NREG-1:0]        en,
    output logic                   hit
);
    logic [NREG-1:0] hit_vec;

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_win
            // one window: enabled and masked address equals masked base
            assign hit_vec[g] = en[g] &&
                ((addr & mask[g*ADDR_W +: ADDR_W]) ==
                 (base[g*ADDR_W +: ADDR_W] & mask[g*ADDR_W +: ADDR_W]));
        end
    endgenerate

    assign hit = |hit_vec;
endmodule

// File: rtl/xg_lane_map.sv
// Byte strobe generation and endian lane mirroring for one word.
// Assumes a 32-bit data path (4 lanes, 2 low address bits).
module xg_lane_map #(
    parameter int DATA_W = 32
) (
    input  logic [1:0]          addr_lo,
    input  logic [1:0]          size,
    input  logic                big,
    input  logic [DATA_W-1:0]   wdata_in,
    input  logic [DATA_W-1:0]   rdata_in,
    output logic [DATA_W/8-1:0] strb,
    output logic [DATA_W-1:0]   wdata_out,
    output logic [DATA_W-1:0]   rdata_out
);
    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0]  le_strb;
    logic [LANES-1:0]  rev_strb;
    logic [DATA_W-1:0] rev_w;
    logic [DATA_W-1:0] rev_r;
    logic              swap;

    // little-endian strobe from size and low address bits
    always_comb begin
        case (size)
            2'd0:    le_strb = LANES'(1) << addr_lo;
            2'd1:    le_strb = LANES'(3) << {addr_lo[1], 1'b0};
            default: le_strb = '1;
        endcase
    end

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            assign rev_strb[g]       = le_strb[LANES-1-g];
            assign rev_w[8*g +: 8]   = wdata_in[8*(LANES-1-g) +: 8];
            assign rev_r[8*g +: 8]   = rdata_in[8*(LANES-1-g) +: 8];
        end
    endgenerate

    // mirror only sub-word accesses in big-endian mode
    always_comb begin
        swap      = big && (size != 2'd2);
        strb      = swap ? rev_strb : le_strb;
        wdata_out = swap ? rev_w : wdata_in;
        rdata_out = swap ? rev_r : rdata_in;
    end
endmodule

// File: rtl/xg_endian_ctl.sv
// Endian-mode register that only changes while the port is quiet.
// Assumes busy is high exactly while a downstream request is open.
module xg_endian_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_val,
    input  logic busy,
    output logic mode
);
    logic held;
    logic held_val;

    // apply, park or release the endian setting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= 1'b0;
            held     <= 1'b0;
            held_val <= 1'b0;
        end else if (wr_en) begin
            if (busy) begin
                held     <= 1'b1;
                held_val <= wr_val;
            end else begin
                mode <= wr_val;
                held <= 1'b0;
            end
        end else if (held && !busy) begin
            mode <= held_val;
            held <= 1'b0;
        end
    end
endmodule

// File: rtl/extmem_ahb_gate.sv
// AHB-Lite slave front end that vets transfers for an external memory
// controller: oversize transfers and protected writes get a two-cycle
// ERROR, legal ones become one valid/ready request with endian-mapped
// lanes. Assumes hready is the bus-wide ready including this slave.
module extmem_ahb_gate
    import extmem_gate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int NREG   = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hsel,
    input  logic [ADDR_W-1:0]      haddr,
    input  logic [1:0]             htrans,
    input  logic                   hwrite,
    input  logic [2:0]             hsize,
    input  logic [DATA_W-1:0]      hwdata,
    input  logic                   hready,
    output logic                   hreadyout,
    output logic                   hresp,
    output logic [DATA_W-1:0]      hrdata,
    input  logic                   cfg_endian_we,
    input  logic                   cfg_endian_val,
    output logic                   endian_mode,
    output logic                   busy,
    input  logic [NREG*ADDR_W-1:0] wp_base,
    input  logic [NREG*ADDR_W-1:0] wp_mask,
    input  logic [NREG-1:0]        wp_en,
    output logic                   req_valid,
    input  logic                   req_ready,
    output logic [ADDR_W-1:0]      req_addr,
    output logic [DATA_W/8-1:0]    req_strb,
    output logic [DATA_W-1:0]      req_wdata,
    output logic                   req_write,
    input  logic [DATA_W-1:0]      rsp_rdata
);
    gate_state_t       state;
    logic [ADDR_W-1:0] a_addr;
    logic [1:0]        a_size;
    logic              a_write;
    logic [DATA_W-1:0] rd_q;
    logic [DATA_W-1:0] rd_mapped;
    logic              slot_free;
    logic              accept;
    logic              prot_hit;
    logic              reject;

    xg_region_match #(.ADDR_W(ADDR_W), .NREG(NREG)) u_match (
        .addr (haddr),
        .base (wp_base),
        .mask (wp_mask),
        .en   (wp_en),
        .hit  (prot_hit)
    );

    xg_lane_map #(.DATA_W(DATA_W)) u_lanes (
        .addr_lo   (a_addr[1:0]),
        .size      (a_size),
        .big       (endian_mode),
        .wdata_in  (hwdata),
        .rdata_in  (rsp_rdata),
        .strb      (req_strb),
        .wdata_out (req_wdata),
        .rdata_out (rd_mapped)
    );

    xg_endian_ctl u_endian (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_endian_we),
        .wr_val (cfg_endian_val),
        .busy   (busy),
        .mode   (endian_mode)
    );

    // address-phase decode: acceptance and legality
    always_comb begin
        slot_free = (state != GS_PEND) && (state != GS_ERR1);
        accept    = hsel && hready && htrans[1] && slot_free;
        reject    = (hsize > SZ_WORD) || (hwrite && prot_hit);
    end

    // transfer state sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= GS_IDLE;
        end else begin
            case (state)
                GS_PEND: if (req_ready) state <= GS_DONE;
                GS_ERR1: state <= GS_ERR2;
                default: begin
                    if (accept) state <= reject ? GS_ERR1 : GS_PEND;
                    else        state <= GS_IDLE;
                end
            endcase
        end
    end

    // capture the address phase of a legal transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_addr  <= '0;
            a_size  <= 2'd0;
            a_write <= 1'b0;
        end else if (accept && !reject) begin
            a_addr  <= haddr;
            a_size  <= hsize[1:0];
            a_write <= hwrite;
        end
    end

    // capture mapped read data at the downstream handshake
    always_ff @(posedge clk) begin
        if (!rst_n)                          rd_q <= '0;
        else if (state == GS_PEND && req_ready) rd_q <= rd_mapped;
    end

    // bus and request outputs
    always_comb begin
        hreadyout = slot_free;
        hresp     = (state == GS_ERR1) || (state == GS_ERR2);
        hrdata    = rd_q;
        req_valid = (state == GS_PEND);
        busy      = (state == GS_PEND);
        req_addr  = a_addr;
        req_write = a_write;
    end
endmodule

// File: rtl/extmem_ahb_gate_chk.sv
// Protocol checker for extmem_ahb_gate, attached by bind.
// Assumes the default 32-bit address and data widths.
module extmem_ahb_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hsel,
    input logic        hready,
    input logic [1:0]  htrans,
    input logic [2:0]  hsize,
    input logic        hreadyout,
    input logic        hresp,
    input logic        busy,
    input logic        endian_mode,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_addr,
    input logic        req_write
);
    p_err_tail_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp && !hreadyout) |=> (hresp && hreadyout));

    p_oversize_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hsel && hready && hreadyout && htrans[1] && hsize > 3'd2)
        |=> (hresp && !req_valid));

    p_hold_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready)
        |=> (req_valid && $stable(req_addr) && $stable(req_write)));

    p_done_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (hreadyout && !hresp && !busy));

    p_endian_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(endian_mode));

    p_idle_no_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hreadyout && !(hsel && hready && htrans[1])) |=> !req_valid);
endmodule

bind extmem_ahb_gate extmem_ahb_gate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hsel        (hsel),
    .hready      (hready),
    .htrans      (htrans),
    .hsize       (hsize),
    .hreadyout   (hreadyout),
    .hresp       (hresp),
    .busy        (busy),
    .endian_mode (endian_mode),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_write   (req_write)
);

// File: tb/extmem_ahb_gate_bench.sv
// Bench for extmem_ahb_gate: behavioural model stepped on each rising
// edge, outputs compared shortly after each falling edge.
module extmem_ahb_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel = 1'b0;
    logic [31:0] haddr = '0;
    logic [1:0]  htrans = 2'd0;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = 3'd0;
    logic [31:0] hwdata = '0;
    logic        hready;
    logic        hreadyout;
    logic        hresp;
    logic [31:0] hrdata;
    logic        cfg_we = 1'b0;
    logic        cfg_val = 1'b0;
    logic        endian_mode;
    logic        busy;
    logic [63:0] wp_base = '0;
    logic [63:0] wp_mask = '0;
    logic [1:0]  wp_en = 2'b00;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr;
    logic [3:0]  req_strb;
    logic [31:0] req_wdata;
    logic        req_write;
    logic [31:0] rsp_rdata = '0;

    assign hready = hreadyout;

    always #4 clk = ~clk;

    extmem_ahb_gate u_extmem_ahb_gate (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr),
        .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata),
        .hready(hready), .hreadyout(hreadyout), .hresp(hresp),
        .hrdata(hrdata), .cfg_endian_we(cfg_we), .cfg_endian_val(cfg_val),
        .endian_mode(endian_mode), .busy(busy), .wp_base(wp_base),
        .wp_mask(wp_mask), .wp_en(wp_en), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_strb(req_strb),
        .req_wdata(req_wdata), .req_write(req_write), .rsp_rdata(rsp_rdata)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string sec = "R1";
    int    ready_lat = 0;
    int    wait_cnt = 0;

    // model state: 0 idle, 1 pending, 2 error first, 3 error second, 4 done
    int          m_phase = 0;
    logic [31:0] m_addr = '0;
    int          m_size = 0;
    bit          m_write = 0;
    bit          m_mode = 0;
    bit          m_pend = 0;
    bit          m_pval = 0;
    logic [31:0] m_rdata = '0;

    function automatic logic [31:0] bswap(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    function automatic logic [3:0] exp_strb(input logic [1:0] a, input int sz, input bit big);
        logic [3:0] s;
        if (sz == 0)      s = 4'b0001 << a;
        else if (sz == 1) s = a[1] ? 4'b1100 : 4'b0011;
        else              s = 4'b1111;
        if (big && sz < 2) s = {s[0], s[1], s[2], s[3]};
        return s;
    endfunction

    function automatic bit is_prot(input logic [31:0] a);
        bit h = 0;
        for (int k = 0; k < 2; k++)
            if (wp_en[k] && ((a & wp_mask[32*k +: 32]) == (wp_base[32*k +: 32] & wp_mask[32*k +: 32])))
                h = 1;
        return h;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s) %s: actual %h expected %h", tag, sec, what, act, exp);
        end
    endtask

    // reference model, one step per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_mode = 0; m_pend = 0; m_pval = 0; m_rdata = '0;
        end else begin
            bit was_busy;
            bit rdy;
            was_busy = (m_phase == 1);
            rdy = !(m_phase == 1 || m_phase == 2);
            if (m_phase == 1) begin
                if (req_ready) begin
                    m_rdata = (m_mode && m_size < 2) ? bswap(rsp_rdata) : rsp_rdata;
                    m_phase = 4;
                end
            end else if (m_phase == 2) begin
                m_phase = 3;
            end else if (rdy && hsel && htrans[1]) begin
                if (hsize > 3'd2 || (hwrite && is_prot(haddr))) m_phase = 2;
                else begin
                    m_phase = 1; m_addr = haddr; m_size = int'(hsize); m_write = hwrite;
                end
            end else begin
                m_phase = 0;
            end
            if (cfg_we) begin
                if (was_busy) begin m_pend = 1; m_pval = cfg_val; end
                else begin m_mode = cfg_val; m_pend = 0; end
            end else if (m_pend && !was_busy) begin
                m_mode = m_pval; m_pend = 0;
            end
        end
    end

    // downstream responder
    always @(negedge clk) begin
        if (m_phase == 1) begin
            req_ready = (wait_cnt >= ready_lat);
            rsp_rdata = 32'h8C4D_2E1F ^ m_addr;
            wait_cnt++;
        end else begin
            req_ready = 1'b0;
            wait_cnt = 0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (cmp_on && !done) begin
            chk(hreadyout, (m_phase == 1 || m_phase == 2) ? 0 : 1, "R2", "hreadyout");
            chk(hresp, (m_phase == 2 || m_phase == 3) ? 1 : 0, "R5", "hresp");
            chk(req_valid, m_phase == 1, "R2", "req_valid");
            chk(busy, m_phase == 1, "R10", "busy");
            chk(endian_mode, m_mode, "R11", "endian_mode");
            if (m_phase == 1) begin
                chk(req_addr, m_addr, "R2", "req_addr");
                chk(req_write, m_write, "R2", "req_write");
                chk(req_strb, exp_strb(m_addr[1:0], m_size, m_mode), m_mode ? "R8" : "R7", "req_strb");
                if (m_write)
                    chk(req_wdata, (m_mode && m_size < 2) ? bswap(hwdata) : hwdata,
                        m_mode ? "R8" : "R7", "req_wdata");
            end
            if (m_phase == 4 && !m_write) chk(hrdata, m_rdata, "R9", "hrdata");
        end
    end

    task automatic xfer(input logic [31:0] a, input int sz, input bit wr, input logic [31:0] d, input int lat);
        ready_lat = lat;
        @(negedge clk);
        hsel = 1; htrans = 2'd2; haddr = a; hsize = 3'(sz); hwrite = wr;
        @(negedge clk);
        hsel = 0; htrans = 2'd0; hwdata = d;
        while (hreadyout !== 1'b1) @(negedge clk);
    endtask

    task automatic quiet(input int n, input bit sel, input logic [1:0] tr);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hsel = sel; htrans = tr; haddr = 32'h0000_0040; hwrite = 1; hsize = 3'd2;
        end
        @(negedge clk);
        hsel = 0; htrans = 2'd0;
    endtask

    task automatic set_endian(input bit v);
        @(negedge clk);
        cfg_we = 1; cfg_val = v;
        @(negedge clk);
        cfg_we = 0;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        cmp_on = 1;                       // R1: reset values compared while in reset
        repeat (2) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        sec = "R7";
        xfer(32'h0000_1000, 2, 1, 32'hDEAD_BEEF, 0);
        for (int a = 0; a < 4; a++) xfer(32'h0000_1010 + a, 0, 1, 32'h1122_3344, 1);
        xfer(32'h0000_1020, 1, 1, 32'hA1B2_C3D4, 0);
        xfer(32'h0000_1022, 1, 1, 32'hA1B2_C3D4, 2);
        sec = "R9";
        xfer(32'h0000_1031, 0, 0, '0, 3);
        xfer(32'h0000_1032, 1, 0, '0, 0);
        xfer(32'h0000_1034, 2, 0, '0, 1);

        sec = "R3";
        xfer(32'h0000_2000, 3, 0, '0, 0);
        xfer(32'h0000_2000, 4, 1, 32'h5555_AAAA, 0);

        sec = "R4";
        wp_base = {32'h3000_0000, 32'h2000_0000};
        wp_mask = {32'hFFFF_0000, 32'hFFFF_F000};
        wp_en   = 2'b01;
        xfer(32'h2000_0010, 2, 1, 32'h0BAD_0BAD, 0);
        xfer(32'h2000_0010, 2, 0, '0, 1);
        xfer(32'h2000_1010, 2, 1, 32'h600D_600D, 0);
        xfer(32'h3000_0100, 2, 1, 32'h1357_9BDF, 0);
        wp_en = 2'b10;
        xfer(32'h3000_0100, 2, 1, 32'h1357_9BDF, 0);
        xfer(32'h2000_0010, 2, 1, 32'h2468_ACE0, 0);
        wp_en = 2'b00;

        sec = "R6";
        quiet(3, 1'b1, 2'd0);
        quiet(3, 1'b1, 2'd1);
        quiet(3, 1'b0, 2'd2);

        sec = "R11";
        set_endian(1);
        repeat (2) @(negedge clk);
        sec = "R8";
        for (int a = 0; a < 4; a++) xfer(32'h0000_4000 + a, 0, 1, 32'hC0DE_F00D, 0);
        xfer(32'h0000_4010, 1, 1, 32'h0102_0304, 0);
        xfer(32'h0000_4012, 1, 0, '0, 2);
        xfer(32'h0000_4021, 0, 0, '0, 0);
        xfer(32'h0000_4030, 2, 1, 32'h0A0B_0C0D, 0);
        xfer(32'h0000_4034, 2, 0, '0, 1);

        sec = "R12";
        fork
            xfer(32'h0000_5000, 0, 1, 32'h7788_99AA, 5);
            begin
                repeat (3) @(negedge clk);
                @(negedge clk); cfg_we = 1; cfg_val = 1'b1;
                @(negedge clk); cfg_val = 1'b0;
                @(negedge clk); cfg_we = 0;
            end
        join
        repeat (3) @(negedge clk);
        xfer(32'h0000_5003, 0, 1, 32'h7788_99AA, 0);
        repeat (3) @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog (%s): actual timeout expected completion", sec);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule